// File: doc/BRIEF.md
# Trace Window Start/Stop Detector

The block watches the 3-bit status code that a processor's program-trace port presents on every clock. It decides when a trace window opens and closes, and it tells the downstream samplers when to record. One code value serves two purposes on that port. It is a window marker only when the code on the clock before it was one of the three lowest codes. In every other case it is an ordinary status value. The block keeps the previous code in a register and qualifies each candidate marker against it.

Each qualified marker toggles the window. After an opening marker, the block classifies the first classifiable code as one of three start kinds: a sequential start, a direct taken branch or an indirect taken branch. Address reconstruction logic downstream uses this tag to choose its rule. The block does not compute addresses itself. While the window is open, the block drives a capture enable to the status, flush and show-cycle address samplers. This enable drops in the very cycle the closing marker appears. When the window closes, the block reports how many of the trailing instruction reports must be treated as possibly invalid, up to a maximum of two.

The status stream cannot be stalled, so there is no ready signal and no back-pressure. A code is consumed on every clock edge. The capture enable works as the valid qualifier for the samplers, and the samplers must accept data on every cycle in which it is high.

Top module: `tw_window_detector`

## Requirements
- R1: A code of 3'b011 is a qualified marker (`mark_seen` high, combinationally) only when the code on the previous clock was 3'b000, 3'b001 or 3'b010. Otherwise 3'b011 is treated as an ordinary status code, both in idle and inside a window.
- R2: A qualified marker seen while idle sets `win_active` from the next clock. A qualified marker seen while the window is open clears `win_active` from the next clock.
- R3: After an opening marker, the first classifying code sets `start_kind` on the next clock and pulses `start_valid` for one clock. The classifying codes are 3'b001 (sequential, kind 2'b01), 3'b110 (direct taken branch, kind 2'b10) and 3'b101 (indirect taken branch, kind 2'b11).
- R4: While a start is still pending, any other non-marker code leaves `start_kind` at 2'b00 (unknown) and `start_valid` low. The window stays armed, and a later classifying code still sets the kind.
- R5: `cap_en` is high in every cycle in which the window is open and the current code is not a qualified marker. It is low in the opening-marker cycle, low in the closing-marker cycle (combinationally), and low while idle.
- R6: One clock after a closing marker, `win_close` pulses for one clock and `tail_drop` holds the smaller of 2 and the number of instruction reports captured in that window. An instruction report is a captured code other than 3'b000.
- R7: A synchronous active-high `rst` returns the block to idle, clears `start_kind`, `start_valid` and `win_close`, and clears the previous-code register to 3'b000. As a result, a 3'b011 on the first clock after reset qualifies.
- R8: An opening marker clears `start_kind` to 2'b00 on the next clock. After a window closes, `start_kind` keeps its value until the next opening marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_code | input | 3 | Per-clock instruction status code |
| win_active | output | 1 | Trace window open (registered) |
| cap_en | output | 1 | Capture enable for the status, flush and address samplers |
| mark_seen | output | 1 | Current code is a qualified window marker |
| start_kind | output | 2 | Start-point kind: 00 unknown, 01 sequential, 10 direct, 11 indirect |
| start_valid | output | 1 | One-clock pulse when `start_kind` is set by classification |
| win_close | output | 1 | One-clock pulse after a closing marker |
| tail_drop | output | 2 | Number of trailing instruction reports to treat as invalid |

## Verification
The bound checker watches several rules on every clock:
- a marker opens or closes the window on the next edge;
- no capture happens in the cycle before a close pulse;
- an unqualified 3'b011 after a high predecessor never raises the marker;
- a start pulse never carries the unknown kind;
- the tail count never exceeds two;
- reset leaves the block idle.

Some behaviour only the directed scenarios can show. These are the exact kind encodings for each classifying code, an armed window that waits through unknown codes before it classifies, and an unqualified 3'b011 in the middle of an open window. The scenarios also cover the exact tail counts of zero, one and two, and the cleared previous-code register just after a reset taken mid-window.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [1:0] {
    KIND_UNKNOWN  = 2'b00,
    KIND_SEQ      = 2'b01,
    KIND_DIRECT   = 2'b10,
    KIND_INDIRECT = 2'b11
  } start_kind_e;

  typedef enum logic [1:0] {
    WST_IDLE  = 2'b00,
    WST_ARMED = 2'b01,
    WST_RUN   = 2'b10
  } win_state_e;

endpackage

// File: rtl/tw_marker_qual.sv
module tw_marker_qual #(
  parameter int                 CODE_W     = 3,
  parameter logic [CODE_W-1:0]  MARK_CODE  = 3'b011,
  parameter logic [CODE_W-1:0]  QUAL_LIMIT = 3'b010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic              mark
);

  localparam logic [CODE_W-1:0] PREV_RESET = '0;

  logic [CODE_W-1:0] prev_q;

  // previous-code register, cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= PREV_RESET;
    end else begin
      prev_q <= code;
    end
  end

  logic is_mark_code;
  logic pred_ok;

  always_comb begin
    is_mark_code = (code == MARK_CODE);
    pred_ok      = (prev_q <= QUAL_LIMIT);
    mark         = is_mark_code && pred_ok;
  end

endmodule

// File: rtl/tw_start_classifier.sv
module tw_start_classifier
  import tw_pkg::*;
#(
  parameter int                CODE_W   = 3,
  parameter logic [CODE_W-1:0] SEQ_CODE = 3'b001,
  parameter logic [CODE_W-1:0] DIR_CODE = 3'b110,
  parameter logic [CODE_W-1:0] IND_CODE = 3'b101
) (
  input  logic [CODE_W-1:0] code,
  output start_kind_e       kind
);

  always_comb begin
    if (code == SEQ_CODE) begin
      kind = KIND_SEQ;
    end else if (code == DIR_CODE) begin
      kind = KIND_DIRECT;
    end else if (code == IND_CODE) begin
      kind = KIND_INDIRECT;
    end else begin
      kind = KIND_UNKNOWN;
    end
  end

endmodule

// File: rtl/tw_window_fsm.sv
module tw_window_fsm
  import tw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        mark,
  input  start_kind_e cls_kind,
  output logic        active,
  output logic        open_evt,
  output logic        close_evt,
  output start_kind_e kind_q,
  output logic        start_pulse_q,
  output logic        close_pulse_q
);

  win_state_e  state_q;
  win_state_e  state_d;
  start_kind_e kind_d;
  logic        classify;

  always_comb begin
    active    = (state_q != WST_IDLE);
    open_evt  = (state_q == WST_IDLE) && mark;
    close_evt = active && mark;
    classify  = (state_q == WST_ARMED) && !mark && (cls_kind != KIND_UNKNOWN);
  end

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    unique case (state_q)
      WST_IDLE: begin
        if (mark) begin
          state_d = WST_ARMED;
          kind_d  = KIND_UNKNOWN;
        end
      end
      WST_ARMED: begin
        if (mark) begin
          state_d = WST_IDLE;
        end else if (classify) begin
          state_d = WST_RUN;
          kind_d  = cls_kind;
        end
      end
      WST_RUN: begin
        if (mark) begin
          state_d = WST_IDLE;
        end
      end
      default: begin
        state_d = WST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= WST_IDLE;
      kind_q        <= KIND_UNKNOWN;
      start_pulse_q <= 1'b0;
      close_pulse_q <= 1'b0;
    end else begin
      state_q       <= state_d;
      kind_q        <= kind_d;
      start_pulse_q <= classify;
      close_pulse_q <= close_evt;
    end
  end

endmodule

// File: rtl/tw_tail_tracker.sv
module tw_tail_tracker #(
  parameter int                CODE_W     = 3,
  parameter logic [CODE_W-1:0] NONE_CODE  = 3'b000,
  parameter int                TAIL_DEPTH = 2,
  localparam int               TAIL_W     = $clog2(TAIL_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              capture,
  input  logic              latch,
  input  logic [CODE_W-1:0] code,
  output logic [TAIL_W-1:0] tail_q
);

  localparam logic [TAIL_W-1:0] SAT_VAL = TAIL_W'(TAIL_DEPTH);

  logic [TAIL_W-1:0] cnt_q;
  logic              is_inst;
  logic              bump;

  always_comb begin
    is_inst = (code != NONE_CODE);
    bump    = capture && is_inst && (cnt_q != SAT_VAL);
  end

  // saturating count of instruction reports in the current window
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (bump) begin
      cnt_q <= cnt_q + TAIL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q <= '0;
    end else if (latch) begin
      tail_q <= cnt_q;
    end
  end

endmodule

// File: rtl/tw_window_detector.sv
module tw_window_detector
  import tw_pkg::*;
#(
  parameter int                CODE_W     = 3,
  parameter logic [CODE_W-1:0] MARK_CODE  = 3'b011,
  parameter logic [CODE_W-1:0] QUAL_LIMIT = 3'b010,
  parameter logic [CODE_W-1:0] SEQ_CODE   = 3'b001,
  parameter logic [CODE_W-1:0] DIR_CODE   = 3'b110,
  parameter logic [CODE_W-1:0] IND_CODE   = 3'b101,
  parameter logic [CODE_W-1:0] NONE_CODE  = 3'b000,
  parameter int                TAIL_DEPTH = 2,
  localparam int               TAIL_W     = $clog2(TAIL_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] stat_code,
  output logic              win_active,
  output logic              cap_en,
  output logic              mark_seen,
  output logic [1:0]        start_kind,
  output logic              start_valid,
  output logic              win_close,
  output logic [TAIL_W-1:0] tail_drop
);

  logic        mark_w;
  start_kind_e cls_kind_w;
  logic        active_w;
  logic        open_w;
  logic        close_w;
  start_kind_e kind_w;
  logic        start_pulse_w;
  logic        close_pulse_w;
  logic        capture_w;

  tw_marker_qual #(
    .CODE_W     (CODE_W),
    .MARK_CODE  (MARK_CODE),
    .QUAL_LIMIT (QUAL_LIMIT)
  ) u_qual (
    .clk  (clk),
    .rst  (rst),
    .code (stat_code),
    .mark (mark_w)
  );

  tw_start_classifier #(
    .CODE_W   (CODE_W),
    .SEQ_CODE (SEQ_CODE),
    .DIR_CODE (DIR_CODE),
    .IND_CODE (IND_CODE)
  ) u_cls (
    .code (stat_code),
    .kind (cls_kind_w)
  );

  tw_window_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .mark          (mark_w),
    .cls_kind      (cls_kind_w),
    .active        (active_w),
    .open_evt      (open_w),
    .close_evt     (close_w),
    .kind_q        (kind_w),
    .start_pulse_q (start_pulse_w),
    .close_pulse_q (close_pulse_w)
  );

  // capture stops in the very cycle of the closing marker
  assign capture_w = active_w && !mark_w;

  tw_tail_tracker #(
    .CODE_W     (CODE_W),
    .NONE_CODE  (NONE_CODE),
    .TAIL_DEPTH (TAIL_DEPTH)
  ) u_tail (
    .clk     (clk),
    .rst     (rst),
    .clear   (open_w),
    .capture (capture_w),
    .latch   (close_w),
    .code    (stat_code),
    .tail_q  (tail_drop)
  );

  assign win_active  = active_w;
  assign cap_en      = capture_w;
  assign mark_seen   = mark_w;
  assign start_kind  = kind_w;
  assign start_valid = start_pulse_w;
  assign win_close   = close_pulse_w;

endmodule

// File: rtl/tw_window_checker.sv
module tw_window_checker #(
  parameter int                CODE_W     = 3,
  parameter logic [CODE_W-1:0] MARK_CODE  = 3'b011,
  parameter logic [CODE_W-1:0] QUAL_LIMIT = 3'b010,
  parameter int                TAIL_DEPTH = 2,
  parameter int                TAIL_W     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] stat_code,
  input logic              win_active,
  input logic              cap_en,
  input logic              mark_seen,
  input logic [1:0]        start_kind,
  input logic              start_valid,
  input logic              win_close,
  input logic [TAIL_W-1:0] tail_drop
);

  a_r1_marker_code: assert property (@(posedge clk) disable iff (rst)
    mark_seen |-> (stat_code == MARK_CODE));

  a_r1_unqualified: assert property (@(posedge clk) disable iff (rst)
    ((stat_code == MARK_CODE) && !$past(rst) && ($past(stat_code) > QUAL_LIMIT)) |-> !mark_seen);

  a_r2_open: assert property (@(posedge clk) disable iff (rst)
    (!win_active && mark_seen) |=> win_active);

  a_r2_close: assert property (@(posedge clk) disable iff (rst)
    (win_active && mark_seen) |=> (!win_active && win_close));

  a_r3_kind_known: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> (start_kind != 2'b00));

  a_r5_no_capture_at_close: assert property (@(posedge clk) disable iff (rst)
    win_close |-> (!$past(cap_en) && $past(win_active)));

  a_r6_tail_bound: assert property (@(posedge clk) disable iff (rst)
    win_close |-> (int'(tail_drop) <= TAIL_DEPTH));

  a_r7_reset_idle: assert property (@(posedge clk)
    rst |=> (!win_active && !start_valid && !win_close && (start_kind == 2'b00)));

endmodule

bind tw_window_detector tw_window_checker #(
  .CODE_W     (CODE_W),
  .MARK_CODE  (MARK_CODE),
  .QUAL_LIMIT (QUAL_LIMIT),
  .TAIL_DEPTH (TAIL_DEPTH),
  .TAIL_W     (TAIL_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stat_code   (stat_code),
  .win_active  (win_active),
  .cap_en      (cap_en),
  .mark_seen   (mark_seen),
  .start_kind  (start_kind),
  .start_valid (start_valid),
  .win_close   (win_close),
  .tail_drop   (tail_drop)
);

// File: tb/tw_window_detector_bench.sv
module tw_window_detector_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] stat_code = 3'b000;
  logic       win_active, cap_en, mark_seen, start_valid, win_close;
  logic [1:0] start_kind;
  logic [1:0] tail_drop;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic cap_s, mark_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_window_detector u_tw_window_detector (
    .clk(clk), .rst(rst), .stat_code(stat_code),
    .win_active(win_active), .cap_en(cap_en), .mark_seen(mark_seen),
    .start_kind(start_kind), .start_valid(start_valid),
    .win_close(win_close), .tail_drop(tail_drop)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // drive a code at the falling edge, sample combinational outputs, then
  // wait past the rising edge so registered outputs reflect this code
  task automatic step(input logic [2:0] c);
    @(negedge clk);
    stat_code = c;
    #1;
    cap_s  = cap_en;
    mark_s = mark_seen;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(3'b000);
    step(3'b000);
    chk("R7 win_active after reset", win_active, 0);
    chk("R7 start_kind after reset", start_kind, 0);
    chk("R7 start_valid after reset", start_valid, 0);
    chk("R7 win_close after reset", win_close, 0);
    rst = 1'b0;
    step(3'b000);
    chk("R5 cap_en idle", cap_s, 0);
  endtask

  task automatic t_seq_start;
    step(3'b011);
    chk("R1 marker after 000", mark_s, 1);
    chk("R5 no capture on opening marker", cap_s, 0);
    chk("R2 window opens", win_active, 1);
    chk("R8 kind cleared on open", start_kind, 0);
    step(3'b001);
    chk("R5 capture in window", cap_s, 1);
    chk("R3 sequential kind", start_kind, 1);
    chk("R3 start pulse", start_valid, 1);
    step(3'b000);
    chk("R3 start pulse one clock", start_valid, 0);
    step(3'b011);
    chk("R5 capture stops on closing marker", cap_s, 0);
    chk("R2 window closes", win_active, 0);
    chk("R6 close pulse", win_close, 1);
    chk("R6 tail one", tail_drop, 1);
    step(3'b000);
    chk("R6 close pulse one clock", win_close, 0);
    chk("R8 kind held after close", start_kind, 1);
  endtask

  task automatic t_direct_start;
    step(3'b011);
    step(3'b110);
    chk("R3 direct kind", start_kind, 2);
    chk("R3 direct pulse", start_valid, 1);
    step(3'b001);
    step(3'b001);
    step(3'b011);
    chk("R6 tail saturates at two", tail_drop, 2);
    chk("R2 direct window closed", win_active, 0);
    step(3'b000);
  endtask

  task automatic t_indirect_start;
    step(3'b011);
    step(3'b101);
    chk("R3 indirect kind", start_kind, 3);
    step(3'b011);
    chk("R1 011 after 101 not a marker", mark_s, 0);
    chk("R1 window stays open", win_active, 1);
    chk("R5 unqualified 011 captured", cap_s, 1);
    step(3'b010);
    step(3'b011);
    chk("R1 marker after 010", mark_s, 1);
    chk("R2 indirect window closed", win_active, 0);
    chk("R6 indirect tail", tail_drop, 2);
    step(3'b000);
  endtask

  task automatic t_unknown_start;
    step(3'b011);
    step(3'b100);
    chk("R4 kind unknown", start_kind, 0);
    chk("R4 no start pulse", start_valid, 0);
    chk("R4 window armed", win_active, 1);
    step(3'b111);
    step(3'b011);
    chk("R4 unqualified 011 while armed", mark_s, 0);
    chk("R4 still unknown", start_kind, 0);
    step(3'b001);
    chk("R4 late classification", start_kind, 1);
    chk("R4 late start pulse", start_valid, 1);
    step(3'b011);
    chk("R6 tail after unknown codes", tail_drop, 2);
    step(3'b000);
  endtask

  task automatic t_idle_unqualified;
    step(3'b101);
    step(3'b011);
    chk("R1 idle 011 after 101", mark_s, 0);
    chk("R1 stays idle", win_active, 0);
    step(3'b011);
    chk("R1 011 after 011", mark_s, 0);
    step(3'b000);
  endtask

  task automatic t_empty_window;
    step(3'b011);
    step(3'b000);
    step(3'b011);
    chk("R6 close pulse empty window", win_close, 1);
    chk("R6 tail zero", tail_drop, 0);
    chk("R8 kind unknown after empty window", start_kind, 0);
    step(3'b000);
  endtask

  task automatic t_reset_mid_window;
    step(3'b011);
    step(3'b001);
    @(negedge clk);
    rst = 1'b1;
    stat_code = 3'b101;
    @(posedge clk);
    #1;
    chk("R7 mid-window reset idle", win_active, 0);
    chk("R7 mid-window reset kind", start_kind, 0);
    rst = 1'b0;
    step(3'b011);
    chk("R7 previous code cleared", mark_s, 1);
    chk("R7 opens after reset", win_active, 1);
    step(3'b001);
    step(3'b011);
    step(3'b000);
  endtask

  initial begin
    t_reset();
    t_seq_start();
    t_direct_start();
    t_indirect_start();
    t_unknown_start();
    t_idle_unqualified();
    t_empty_window();
    t_reset_mid_window();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule